// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block is the first stage of a Reed-Solomon decoder for the RS(255,239) code over GF(2^8). Each codeword holds 239 data symbols followed by 16 parity symbols. A correct codeword is a multiple of the generator polynomial, so all 16 syndromes are zero. A nonzero syndrome vector tells the later stages that errors are present, and it gives them what they need to find and fix up to 8 symbol errors.

One 8-bit symbol enters per clock while `in_valid` is high. `in_start` marks the first symbol of a codeword, and symbols arrive highest-order coefficient first. Sixteen lanes run side by side. Each lane holds an accumulator and updates it by Horner's rule: it multiplies the accumulator by a fixed power of the primitive element, then XORs in the new symbol. The cycle after the 255th symbol is absorbed, the block registers all sixteen results. It raises a one-cycle done strobe and a flag that says whether every syndrome is zero. A new codeword may begin on the very next clock.

Top module: `rs_syn_top`

## Requirements
- R1: The field uses the primitive polynomial x^8+x^4+x^3+x^2+1 (0x11D), with α = 0x02. The first symbol accepted in a codeword is the coefficient of x^254. `synd_flat[8(j-1)+7 : 8(j-1)]` carries S_j = r(α^j) for j = 1..16, so S1 sits in the low byte.
- R2: For a valid codeword (data followed by the remainder of division by the product of (x+α^j), j=1..16), every syndrome is 0 and `synd_zero` is 1.
- R3: A codeword with one or more corrupted symbols gives the syndromes defined in R1. If any of them is nonzero, `synd_zero` is 0. An error of value v on the last symbol makes every syndrome equal v.
- R4: `synd_valid` is high for exactly one cycle. That cycle is the one right after the clock edge that accepts the 255th symbol of a codeword.
- R5: Cycles with `in_valid` low inside a codeword have no effect on the result.
- R6: `in_valid` with `in_start` always opens a new codeword and discards any partial one. Codewords may follow each other with no idle cycle.
- R7: A symbol with `in_valid` high but `in_start` low, arriving while no codeword is open, is ignored. It produces no strobe and changes no output.
- R8: `synd_flat` and `synd_zero` hold their values between strobes.
- R9: Reset sets `synd_valid`, `synd_flat` and `synd_zero` to 0 and leaves no codeword open.
- R10: `synd_zero` is 1 only when all of `synd_flat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A symbol is present this cycle |
| in_start | input | 1 | The present symbol is the first of a codeword |
| in_sym | input | 8 | Received symbol |
| synd_valid | output | 1 | One-cycle strobe: a new syndrome set is available |
| synd_flat | output | 128 | S1..S16, with S1 in the low byte |
| synd_zero | output | 1 | All syndromes of the last codeword are zero |

## Verification
A faulty lane constant or multiplier shows up as one wrong byte in `synd_flat` at the first strobe after any codeword with an error. Valid codewords hide it, because their syndromes are zero for every root. For this reason the bench mixes encoded codewords with injected errors and random words. A symbol counter that is off by one moves the strobe away from the cycle after the 255th accepted symbol, and it also shifts every syndrome. Both symptoms appear at the first codeword. A fault in start or stall handling appears only on the codewords that use restarts, bubbles or stray symbols, and it shows at that codeword's strobe or as an unexpected strobe.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

  // Multiply by x in GF(2^m) with field polynomial poly (m <= 16).
  function automatic logic [15:0] gf_xtime(input logic [15:0] a, input int m,
                                           input logic [16:0] poly);
    logic [16:0] t;
    logic [16:0] mask;
    t    = {a, 1'b0};
    mask = (17'd1 << m) - 17'd1;
    if (t[m]) t = t ^ poly;
    return 16'(t & mask);
  endfunction

  // General field product, bit-serial over b, most significant bit first.
  function automatic logic [15:0] gf_mul(input logic [15:0] a, input logic [15:0] b,
                                         input int m, input logic [16:0] poly);
    logic [15:0] r;
    r = '0;
    for (int i = 15; i >= 0; i--) begin
      if (i < m) begin
        r = gf_xtime(r, m, poly);
        if (b[i]) r = r ^ a;
      end
    end
    return r;
  endfunction

  // alpha^e with alpha = x.
  function automatic logic [15:0] gf_alpha_pow(input int e, input int m,
                                               input logic [16:0] poly);
    logic [15:0] r;
    r = 16'd1;
    for (int i = 0; i < e; i++) r = gf_xtime(r, m, poly);
    return r;
  endfunction

endpackage

// File: rtl/rs_syn_lane.sv
module rs_syn_lane #(
  parameter int              SYM_W    = 8,
  parameter logic [SYM_W:0]  POLY     = 9'h11D,
  parameter int              ROOT_EXP = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic             load,
  input  logic [SYM_W-1:0] din,
  output logic [SYM_W-1:0] acc_nxt
);
  import rs_syn_pkg::*;

  localparam logic [16:0] POLY17 = 17'(POLY);
  localparam logic [15:0] ROOT   = gf_alpha_pow(ROOT_EXP, SYM_W, POLY17);

  logic [SYM_W-1:0] acc_q;

  // Horner step: acc*alpha^j + r ; the first symbol reloads the lane.
  always_comb begin
    if (load) acc_nxt = din;
    else      acc_nxt = SYM_W'(gf_mul(16'(acc_q), ROOT, SYM_W, POLY17)) ^ din;
  end

  always_ff @(posedge clk) begin
    if (rst)         acc_q <= '0;
    else if (acc_en) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/rs_syn_ctrl.sv
module rs_syn_ctrl #(
  parameter int CW_LEN = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_start,
  output logic accept,
  output logic load,
  output logic last
);
  localparam int CNT_W = ($clog2(CW_LEN) > 0) ? $clog2(CW_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CW_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             open_q;

  always_comb begin
    idx    = in_start ? '0 : cnt_q;
    accept = in_valid && (in_start || open_q);
    load   = in_valid && in_start;
    last   = accept && (idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (accept) begin
      if (last) begin
        cnt_q  <= '0;
        open_q <= 1'b0;
      end else begin
        cnt_q  <= idx + 1'b1;
        open_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_syn_out.sv
module rs_syn_out #(
  parameter int FLAT_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [FLAT_W-1:0] synd_in,
  output logic              synd_valid,
  output logic [FLAT_W-1:0] synd_flat,
  output logic              synd_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      synd_valid <= 1'b0;
      synd_flat  <= '0;
      synd_zero  <= 1'b0;
    end else begin
      synd_valid <= capture;
      if (capture) begin
        synd_flat <= synd_in;
        synd_zero <= ~|synd_in;
      end
    end
  end
endmodule

// File: rtl/rs_syn_top.sv
module rs_syn_top #(
  parameter int             SYM_W      = 8,
  parameter int             CW_LEN     = 255,
  parameter int             NSYND      = 16,
  parameter int             FIRST_ROOT = 1,
  parameter logic [SYM_W:0] POLY       = 9'h11D
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_start,
  input  logic [SYM_W-1:0]         in_sym,
  output logic                     synd_valid,
  output logic [NSYND*SYM_W-1:0]   synd_flat,
  output logic                     synd_zero
);
  localparam int FLAT_W = NSYND * SYM_W;

  logic              accept;
  logic              load;
  logic              last;
  logic [FLAT_W-1:0] nxt_flat;

  rs_syn_ctrl #(.CW_LEN(CW_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .accept(accept), .load(load), .last(last)
  );

  for (genvar j = 0; j < NSYND; j++) begin : g_lane
    rs_syn_lane #(.SYM_W(SYM_W), .POLY(POLY), .ROOT_EXP(FIRST_ROOT + j)) u_lane (
      .clk(clk), .rst(rst), .acc_en(accept), .load(load), .din(in_sym),
      .acc_nxt(nxt_flat[j*SYM_W +: SYM_W])
    );
  end

  rs_syn_out #(.FLAT_W(FLAT_W)) u_out (
    .clk(clk), .rst(rst), .capture(last), .synd_in(nxt_flat),
    .synd_valid(synd_valid), .synd_flat(synd_flat), .synd_zero(synd_zero)
  );
endmodule

// File: rtl/rs_syn_chk.sv
module rs_syn_chk #(
  parameter int CW_LEN = 255,
  parameter int FLAT_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              synd_valid,
  input logic [FLAT_W-1:0] synd_flat,
  input logic              synd_zero
);
  int   gap_q;
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (synd_valid) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else if (gap_q < CW_LEN) begin
      gap_q  <= gap_q + 1;
    end
  end

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    synd_valid |=> !synd_valid);

  assert_strobe_after_symbol_R4: assert property (@(posedge clk) disable iff (rst)
    synd_valid |-> $past(in_valid));

  assert_strobe_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (synd_valid && seen_q) |-> (gap_q >= CW_LEN - 1));

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !synd_valid |-> ($stable(synd_flat) && $stable(synd_zero)));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!synd_valid && synd_flat == '0 && !synd_zero));

  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (rst)
    synd_zero |-> (synd_flat == '0));
endmodule

bind rs_syn_top rs_syn_chk #(.CW_LEN(CW_LEN), .FLAT_W(NSYND*SYM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .synd_valid(synd_valid),
  .synd_flat(synd_flat), .synd_zero(synd_zero)
);

// File: tb/rs_syn_top_bench.sv
`timescale 1ns/1ps
module rs_syn_top_bench;
  localparam int N  = 255;
  localparam int K  = 239;
  localparam int NS = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_start;
  logic [7:0]   in_sym;
  logic         synd_valid, synd_zero;
  logic [127:0] synd_flat;

  always #2.5 clk = ~clk;

  rs_syn_top u_rs_syn_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start), .in_sym(in_sym),
    .synd_valid(synd_valid), .synd_flat(synd_flat), .synd_zero(synd_zero)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done_all = 0;

  logic [7:0]   word  [0:N-1];
  logic [7:0]   gpoly [0:NS];
  logic [127:0] exp_v [0:63];
  int           exp_due [0:63];
  string        exp_tag [0:63];
  int wr = 0;
  int rd = 0;
  logic [127:0] last_exp = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] bpow(input int e);
    logic [7:0] r = 8'd1;
    for (int i = 0; i < e; i++) r = bmul(r, 8'h02);
    return r;
  endfunction

  function automatic logic [127:0] ref_synd();
    logic [127:0] v = '0;
    for (int j = 1; j <= NS; j++) begin
      logic [7:0] s = 0;
      logic [7:0] a = bpow(j);
      for (int i = 0; i < N; i++) s = bmul(s, a) ^ word[i];
      v[(j-1)*8 +: 8] = s;
    end
    return v;
  endfunction

  task automatic build_gen();
    for (int k = 0; k <= NS; k++) gpoly[k] = 0;
    gpoly[0] = 1;
    for (int r = 1; r <= NS; r++) begin
      logic [7:0] root = bpow(r);
      for (int k = r; k >= 1; k--) gpoly[k] = gpoly[k-1] ^ bmul(gpoly[k], root);
      gpoly[0] = bmul(gpoly[0], root);
    end
  endtask

  task automatic fill_data(input int mode);
    for (int i = 0; i < K; i++) word[i] = (mode == 0) ? 8'h00 : 8'($urandom);
  endtask

  task automatic encode();
    logic [7:0] p [0:NS-1];
    for (int k = 0; k < NS; k++) p[k] = 0;
    for (int i = 0; i < K; i++) begin
      logic [7:0] fb = word[i] ^ p[NS-1];
      for (int k = NS-1; k >= 1; k--) p[k] = p[k-1] ^ bmul(fb, gpoly[k]);
      p[0] = bmul(fb, gpoly[0]);
    end
    for (int m = 0; m < NS; m++) word[K+m] = p[NS-1-m];
  endtask

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Observe strobes at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (!rst && synd_valid) begin
      if (rd == wr) begin
        check(0, "R4/R7 unexpected strobe", 128'(synd_valid), 128'd0);
      end else begin
        check(cyc == exp_due[rd % 64], {"R4 strobe cycle ", exp_tag[rd % 64]},
              128'(cyc), 128'(exp_due[rd % 64]));
        check(synd_flat == exp_v[rd % 64], exp_tag[rd % 64], synd_flat, exp_v[rd % 64]);
        check(synd_zero == (exp_v[rd % 64] == '0), "R10 zero flag",
              128'(synd_zero), 128'(exp_v[rd % 64] == '0));
        last_exp = exp_v[rd % 64];
        rd++;
      end
    end else if (rd != wr && cyc > exp_due[rd % 64]) begin
      check(0, {"R4 missing strobe ", exp_tag[rd % 64]}, 128'd0, 128'd1);
      rd++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_start = 0; in_sym = 8'($urandom);
    end
  endtask

  // Send the whole word; bubbles adds random stall cycles (R5).
  task automatic send_word(input bit bubbles, input string tag);
    logic [127:0] e = ref_synd();
    for (int i = 0; i < N; i++) begin
      if (bubbles) begin
        while ($urandom % 4 == 0) begin
          @(negedge clk);
          in_valid = 0; in_start = 1; in_sym = 8'($urandom);
        end
      end
      @(negedge clk);
      in_valid = 1; in_start = (i == 0); in_sym = word[i];
      if (i == N-1) begin
        exp_v[wr % 64] = e; exp_due[wr % 64] = cyc + 1; exp_tag[wr % 64] = tag;
        wr++;
      end
    end
  endtask

  task automatic send_partial(input int n, input bit with_start);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_start = with_start && (i == 0); in_sym = 8'($urandom);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", 128'(cyc), 128'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    build_gen();
    rst = 1; in_valid = 0; in_start = 0; in_sym = 0;
    repeat (4) @(negedge clk);
    check(!synd_valid && synd_flat == '0 && !synd_zero, "R9 reset state",
          synd_flat, '0);
    rst = 0;

    // R9/R7: stray symbols after reset open no codeword.
    send_partial(12, 0);
    idle(2);
    check(synd_flat == '0 && !synd_zero, "R9 no codeword open after reset", synd_flat, '0);

    // R2: all-zero and random valid codewords.
    fill_data(0); encode();
    send_word(0, "R2 zero codeword");
    idle(3);
    check(synd_flat == last_exp, "R8 hold after strobe", synd_flat, last_exp);
    for (int t = 0; t < 3; t++) begin
      fill_data(1); encode();
      send_word(0, "R2 random codeword back-to-back R6");
    end
    idle(2);

    // R3: single error on the last symbol -> every syndrome equals v.
    fill_data(1); encode();
    word[N-1] ^= 8'h5A;
    send_word(0, "R3 error on last symbol");
    idle(2);
    check(synd_flat == {16{8'h5A}}, "R3 last-symbol error value", synd_flat, {16{8'h5A}});
    check(!synd_zero, "R3 zero flag low", 128'(synd_zero), 128'd0);

    // R1: error on the first symbol (x^254 coefficient).
    fill_data(1); encode();
    word[0] ^= 8'h01;
    send_word(0, "R1 error on first symbol");
    idle(1);

    // R3: 8 and 9 errors, then random words.
    for (int ne = 8; ne <= 9; ne++) begin
      fill_data(1); encode();
      for (int e = 0; e < ne; e++) word[e*27 + 3] ^= 8'(e + 1);
      send_word(0, "R3 multi-error codeword");
    end
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < N; i++) word[i] = 8'($urandom);
      send_word(0, "R1 random word");
    end
    idle(2);

    // R5: stalls inside codewords.
    fill_data(1); encode();
    send_word(1, "R5 valid codeword with stalls");
    fill_data(1); encode(); word[100] ^= 8'hC3;
    send_word(1, "R5 errored codeword with stalls");
    idle(2);

    // R6: restart discards a partial codeword.
    send_partial(100, 1);
    fill_data(1); encode(); word[7] ^= 8'h11;
    send_word(0, "R6 codeword after restart");
    idle(2);

    // R7/R8: stray symbols after a codeword change nothing.
    send_partial(40, 0);
    idle(2);
    check(synd_flat == last_exp, "R7 stray symbols ignored", synd_flat, last_exp);
    check(synd_zero == (last_exp == '0), "R8 zero flag held",
          128'(synd_zero), 128'(last_exp == '0));
    fill_data(1); encode();
    send_word(0, "R7 codeword after stray symbols");
    idle(4);

    check(rd == wr, "R4 all strobes seen", 128'(rd), 128'(wr));
    done_all = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule